// File: doc/BRIEF.md
# Dual-Processor Semaphore Gates

This block holds sixteen hardware lock gates that two processors share over a single-cycle register bus. Each gate has its own byte address and a two-bit state: free, or held by one of the two processors. A processor takes a gate by writing its own owner code while the gate is free, and gives it back by writing the free code while it holds it. Every other write leaves the gate alone. The state read back always shows which processor took the gate last.

A processor whose lock attempt fails does not have to poll. The failed attempt is remembered. When that gate next becomes free, a notification bit for the losing processor is raised. Each processor has an enable mask and one interrupt line, so it can go on with other work until the interrupt sends it back to retry the lock.

The bus answers in the same cycle: read data and the error flag are combinational from the request, and state changes take effect at the clock edge that ends the access.

Top module: `sema_gates`

## Requirements
- R1: After synchronous active-low reset, every gate reads free, both enable masks and both notification registers read zero, and both interrupt lines are low.
- R2: Gate n lives at byte address n. In a 32-bit word at address A, byte lane l (data bits 8l+7..8l) holds gate A+l, with the state in the lane's two lowest bits: 00 free, 01 held by processor 0, 10 held by processor 1. State 11 is never entered.
- R3: A write of a processor's own code (rid 0 writes 01, rid 1 writes 10) locks a free gate. A lock write to a gate held by the other processor, or a write of the other processor's code, changes nothing.
- R4: Only the holder can free a gate, by writing 00. A write of 00 from the other processor leaves the gate held.
- R5: A write byte of 0x03 does nothing to its gate. Write bytes whose upper six bits are not zero also do nothing.
- R6: A read of up to four byte lanes returns the states of up to four gates in one access.
- R7: A write with several byte enables set acts on the gate of the only enabled byte that is not 0x03, and raises no error. Lanes whose byte enable is clear are not counted.
- R8: A write to the gate area in which two or more enabled bytes differ from 0x03 raises bus_err in that cycle and changes no gate.
- R9: The enable masks (16 bits, bit n for gate n) are at 0x40 for processor 0 and 0x48 for processor 1. Byte enables 0 and 1 write bits 7..0 and 15..8. Bits 31..16 read as zero and ignore writes.
- R10: A failed lock attempt by processor p on gate n sets notification bit n of p when gate n next becomes free. The notification registers are read at 0x80 (processor 0) and 0x88 (processor 1), bit n for gate n, and writes to them are ignored.
- R11: irq[p] is high exactly when processor p has a notification bit set whose enable bit is also set.
- R12: Notification bit n of processor p clears when p successfully locks gate n.
- R13: Freeing a gate raises no notification for a processor that made no failed attempt on it since the gate last became free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word-aligned byte address |
| bus_be | input | 4 | Byte-lane enables |
| bus_wdata | input | 32 | Write data |
| bus_rid | input | 1 | Requesting processor (0 or 1) |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| bus_err | output | 1 | Error response for a write that touches several gates |
| irq | output | 2 | Notification interrupt, bit p for processor p |

## Verification
The hardest state to reach from the ports is a pending notification. It needs a gate held by one processor, a lock attempt on it by the other, and then a release by the holder, and it needs these in order. The stimulus builds this in steps. A held gate and a failed attempt are left in place early in the vector table. Directed steps later free the gate, watch the notification and interrupt with the enable set and with it clear, and then check that the bit clears when the waiter takes the lock. A release with no waiter follows, to show that a free event alone raises nothing.

// File: rtl/sema_pkg.sv
// Shared definitions for the semaphore gate block.
// Assumes exactly two processors, so the owner code fits in two bits.
package sema_pkg;

    localparam int NUM_PROCS = 2;

    typedef enum logic [1:0] {
        GATE_FREE = 2'b00,
        GATE_P0   = 2'b01,
        GATE_P1   = 2'b10,
        GATE_RSVD = 2'b11
    } gate_st_e;

    // Write byte value that leaves its gate untouched
    localparam logic [7:0] NOP_BYTE = 8'h03;

    // Owner code a processor writes to take a gate
    function automatic gate_st_e owner_code(input logic rid);
        return rid ? GATE_P1 : GATE_P0;
    endfunction

endpackage

// File: rtl/sema_gate.sv
// One lock gate: a three-state machine (free / held by 0 / held by 1).
// Assumes wr_i is high only for an accepted, error-free write whose byte
// lane maps to this gate. Flags the outcome of the write to the notifier.
module sema_gate
    import sema_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [7:0] byte_i,
    input  logic       rid_i,
    output logic [1:0] state_o,
    output logic       lock_ok_o,
    output logic       lock_fail_o,
    output logic       freed_o
);

    gate_st_e state_q;
    gate_st_e mine;
    gate_st_e code;
    logic     legal;

    // Classify the write against the present state
    always_comb begin
        mine        = owner_code(rid_i);
        code        = gate_st_e'(byte_i[1:0]);
        legal       = wr_i && (byte_i[7:2] == 6'b0);
        lock_ok_o   = legal && (code == mine) && (state_q == GATE_FREE);
        lock_fail_o = legal && (code == mine) && (state_q != GATE_FREE)
                      && (state_q != mine);
        freed_o     = legal && (code == GATE_FREE) && (state_q == mine);
    end

    // Gate state register
    always_ff @(posedge clk) begin
        if (!rst_n)         state_q <= GATE_FREE;
        else if (lock_ok_o) state_q <= mine;
        else if (freed_o)   state_q <= GATE_FREE;
    end

    assign state_o = state_q;

    // R2
    gate_never_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != GATE_RSVD);

    // R3
    gate_lock_from_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != $past(state_q)) && (state_q != GATE_FREE) |->
            ($past(state_q) == GATE_FREE) && $past(wr_i));

    // R4
    gate_unlock_by_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GATE_FREE) && ($past(state_q) != GATE_FREE) |->
            $past(wr_i) && ($past(state_q) == owner_code($past(rid_i))));

endmodule

// File: rtl/sema_notify.sv
// Per-processor notification logic: enable mask, pending-waiter flags and
// notification request bits, plus the interrupt line.
// Assumes fail_i/ok_i are already qualified by this processor's ID and
// freed_i is the per-gate release pulse from the gates.
module sema_notify #(
    parameter int NUM_GATES = 16,
    localparam int ENA_LANES = NUM_GATES / 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_GATES-1:0] fail_i,
    input  logic [NUM_GATES-1:0] ok_i,
    input  logic [NUM_GATES-1:0] freed_i,
    input  logic [ENA_LANES-1:0] ena_we_i,
    input  logic [NUM_GATES-1:0] wdata_i,
    output logic [NUM_GATES-1:0] ena_o,
    output logic [NUM_GATES-1:0] ntf_o,
    output logic                 irq_o
);

    logic [NUM_GATES-1:0] ena_q;
    logic [NUM_GATES-1:0] waiter_q;
    logic [NUM_GATES-1:0] ntf_q;

    // Enable mask, written one byte lane at a time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena_q <= '0;
        end else begin
            for (int l = 0; l < ENA_LANES; l++) begin
                if (ena_we_i[l]) ena_q[8*l +: 8] <= wdata_i[8*l +: 8];
            end
        end
    end

    // Waiter flags arm on a failed lock; request bits fire on release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waiter_q <= '0;
            ntf_q    <= '0;
        end else begin
            waiter_q <= (waiter_q | fail_i) & ~freed_i;
            ntf_q    <= (ntf_q | (waiter_q & freed_i)) & ~ok_i;
        end
    end

    assign ena_o = ena_q;
    assign ntf_o = ntf_q;
    assign irq_o = |(ntf_q & ena_q);

    // R10
    ntf_rise_on_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ntf_q & ~$past(ntf_q) & ~$past(freed_i)) == '0);

    // R13
    ntf_needs_waiter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ntf_q & ~$past(ntf_q) & ~$past(waiter_q)) == '0);

    // R12
    ntf_clear_on_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ok_i) & ntf_q) == '0);

endmodule

// File: rtl/sema_decode.sv
// Bus decoder: maps the access to gate write strobes, enable-mask lane
// strobes, the multi-gate error and the read-data mux.
// Assumes word-aligned addresses and NUM_GATES a multiple of both the lane
// count and eight.
module sema_decode
    import sema_pkg::*;
#(
    parameter int NUM_GATES   = 16,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int ENA_BASE    = 'h40,
    parameter int NTF_BASE    = 'h80,
    parameter int PROC_STRIDE = 8,
    localparam int LANES      = DATA_W / 8,
    localparam int ENA_LANES  = NUM_GATES / 8
) (
    input  logic                                  sel_i,
    input  logic                                  we_i,
    input  logic [ADDR_W-1:0]                     addr_i,
    input  logic [LANES-1:0]                      be_i,
    input  logic [DATA_W-1:0]                     wdata_i,
    input  logic [NUM_GATES-1:0][1:0]             gate_st_i,
    input  logic [NUM_PROCS-1:0][NUM_GATES-1:0]   ena_i,
    input  logic [NUM_PROCS-1:0][NUM_GATES-1:0]   ntf_i,
    output logic [NUM_GATES-1:0]                  gate_wr_o,
    output logic [NUM_GATES-1:0][7:0]             gate_byte_o,
    output logic [NUM_PROCS-1:0][ENA_LANES-1:0]   ena_we_o,
    output logic [DATA_W-1:0]                     rdata_o,
    output logic                                  err_o
);

    localparam int LANE_W = $clog2(LANES);
    localparam int WORD_W = ADDR_W - LANE_W;

    logic             in_gates;
    logic [LANES-1:0] lane_active;
    logic             wr_ok;

    // Which enabled lanes of a gate-area write would touch a gate
    always_comb begin
        in_gates = addr_i < ADDR_W'(NUM_GATES);
        for (int l = 0; l < LANES; l++) begin
            lane_active[l] = in_gates && be_i[l] && (wdata_i[8*l +: 8] != NOP_BYTE);
        end
        err_o = sel_i && we_i && ($countones(lane_active) > 1);
        wr_ok = sel_i && we_i && !err_o;
    end

    // Per-gate write strobe and data byte
    for (genvar n = 0; n < NUM_GATES; n++) begin : g_gate_wr
        assign gate_wr_o[n]   = wr_ok && in_gates
                                && (addr_i[ADDR_W-1:LANE_W] == WORD_W'(n / LANES))
                                && lane_active[n % LANES];
        assign gate_byte_o[n] = wdata_i[8*(n % LANES) +: 8];
    end

    // Per-processor enable-mask lane strobes
    for (genvar p = 0; p < NUM_PROCS; p++) begin : g_ena_we
        for (genvar l = 0; l < ENA_LANES; l++) begin : g_lane
            assign ena_we_o[p][l] = sel_i && we_i && be_i[l]
                && (addr_i == ADDR_W'(ENA_BASE + p * PROC_STRIDE));
        end
    end

    // Read-data mux over gates, enable masks and notification registers
    always_comb begin
        rdata_o = '0;
        if (sel_i && !we_i) begin
            if (in_gates) begin
                for (int l = 0; l < LANES; l++) begin
                    if ((int'(addr_i[ADDR_W-1:LANE_W]) * LANES + l) < NUM_GATES) begin
                        rdata_o[8*l +: 8] =
                            {6'b0, gate_st_i[int'(addr_i[ADDR_W-1:LANE_W]) * LANES + l]};
                    end
                end
            end
            for (int p = 0; p < NUM_PROCS; p++) begin
                if (addr_i == ADDR_W'(ENA_BASE + p * PROC_STRIDE)) rdata_o = DATA_W'(ena_i[p]);
                if (addr_i == ADDR_W'(NTF_BASE + p * PROC_STRIDE)) rdata_o = DATA_W'(ntf_i[p]);
            end
        end
    end

endmodule

// File: rtl/sema_gates.sv
// Top of the dual-processor semaphore block: decoder, gate array and one
// notification unit per processor.
// Assumes a single-cycle bus: rdata and err are valid while bus_sel is high,
// and writes take effect at the clock edge that ends the access.
module sema_gates
    import sema_pkg::*;
#(
    parameter int NUM_GATES   = 16,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int ENA_BASE    = 'h40,
    parameter int NTF_BASE    = 'h80,
    parameter int PROC_STRIDE = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W/8-1:0]  bus_be,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic                 bus_rid,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 bus_err,
    output logic [NUM_PROCS-1:0] irq
);

    localparam int ENA_LANES = NUM_GATES / 8;

    logic [NUM_GATES-1:0]                gate_wr;
    logic [NUM_GATES-1:0][7:0]           gate_byte;
    logic [NUM_GATES-1:0][1:0]           gate_st;
    logic [NUM_GATES-1:0]                gate_ok;
    logic [NUM_GATES-1:0]                gate_fail;
    logic [NUM_GATES-1:0]                gate_freed;
    logic [NUM_PROCS-1:0][ENA_LANES-1:0] ena_we;
    logic [NUM_PROCS-1:0][NUM_GATES-1:0] ena;
    logic [NUM_PROCS-1:0][NUM_GATES-1:0] ntf;

    sema_decode #(
        .NUM_GATES  (NUM_GATES),
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .ENA_BASE   (ENA_BASE),
        .NTF_BASE   (NTF_BASE),
        .PROC_STRIDE(PROC_STRIDE)
    ) u_decode (
        .sel_i      (bus_sel),
        .we_i       (bus_we),
        .addr_i     (bus_addr),
        .be_i       (bus_be),
        .wdata_i    (bus_wdata),
        .gate_st_i  (gate_st),
        .ena_i      (ena),
        .ntf_i      (ntf),
        .gate_wr_o  (gate_wr),
        .gate_byte_o(gate_byte),
        .ena_we_o   (ena_we),
        .rdata_o    (bus_rdata),
        .err_o      (bus_err)
    );

    // One state machine per gate
    for (genvar n = 0; n < NUM_GATES; n++) begin : g_gate
        sema_gate u_gate (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_i       (gate_wr[n]),
            .byte_i     (gate_byte[n]),
            .rid_i      (bus_rid),
            .state_o    (gate_st[n]),
            .lock_ok_o  (gate_ok[n]),
            .lock_fail_o(gate_fail[n]),
            .freed_o    (gate_freed[n])
        );
    end

    // One notification unit per processor, fed outcomes of its own writes
    for (genvar p = 0; p < NUM_PROCS; p++) begin : g_notify
        logic mine;
        assign mine = (bus_rid == 1'(p));

        sema_notify #(.NUM_GATES(NUM_GATES)) u_notify (
            .clk     (clk),
            .rst_n   (rst_n),
            .fail_i  (gate_fail & {NUM_GATES{mine}}),
            .ok_i    (gate_ok & {NUM_GATES{mine}}),
            .freed_i (gate_freed),
            .ena_we_i(ena_we[p]),
            .wdata_i (bus_wdata[NUM_GATES-1:0]),
            .ena_o   (ena[p]),
            .ntf_o   (ntf[p]),
            .irq_o   (irq[p])
        );
    end

    // R8
    err_no_gate_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> $stable(gate_st));

    // R8
    err_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_sel && bus_we);

endmodule

// File: tb/sema_gates_tb.sv
`timescale 1ns/1ps
module sema_gates_tb;

    typedef struct packed {
        logic        rid;
        logic        we;
        logic [7:0]  addr;
        logic [3:0]  be;
        logic [31:0] wd;
        logic [31:0] rd;
        logic        err;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 24;
    // Columns: rid, we, addr, be, wdata, expected rdata (reads), expected err, requirement
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 8'h00, 4'hF, 32'h0,        32'h0,        1'b0, 8'd1 },  // R1 gates free
        '{1'b0, 1'b1, 8'h00, 4'h2, 32'h00000100, 32'h0,        1'b0, 8'd3 },  // R3 p0 locks gate1
        '{1'b0, 1'b0, 8'h00, 4'hF, 32'h0,        32'h00000100, 1'b0, 8'd3 },
        '{1'b1, 1'b1, 8'h00, 4'h2, 32'h00000200, 32'h0,        1'b0, 8'd3 },  // R3 p1 fails gate1
        '{1'b0, 1'b0, 8'h00, 4'hF, 32'h0,        32'h00000100, 1'b0, 8'd3 },
        '{1'b1, 1'b1, 8'h00, 4'h2, 32'h00000000, 32'h0,        1'b0, 8'd4 },  // R4 non-owner free
        '{1'b0, 1'b0, 8'h00, 4'hF, 32'h0,        32'h00000100, 1'b0, 8'd4 },
        '{1'b0, 1'b1, 8'h00, 4'h1, 32'h00000002, 32'h0,        1'b0, 8'd3 },  // R3 wrong code gate0
        '{1'b0, 1'b0, 8'h00, 4'hF, 32'h0,        32'h00000100, 1'b0, 8'd3 },
        '{1'b1, 1'b1, 8'h04, 4'hF, 32'h03020303, 32'h0,        1'b0, 8'd7 },  // R7 wide, one gate
        '{1'b0, 1'b0, 8'h04, 4'hF, 32'h0,        32'h00020000, 1'b0, 8'd6 },  // R6 multi-gate read
        '{1'b0, 1'b1, 8'h04, 4'hF, 32'h03010103, 32'h0,        1'b1, 8'd8 },  // R8 two gates -> err
        '{1'b0, 1'b0, 8'h04, 4'hF, 32'h0,        32'h00020000, 1'b0, 8'd8 },
        '{1'b0, 1'b1, 8'h04, 4'h8, 32'h03000000, 32'h0,        1'b0, 8'd5 },  // R5 nop on gate7
        '{1'b0, 1'b0, 8'h04, 4'hF, 32'h0,        32'h00020000, 1'b0, 8'd5 },
        '{1'b1, 1'b1, 8'h48, 4'hF, 32'hFFFFFFFF, 32'h0,        1'b0, 8'd9 },  // R9 enable p1
        '{1'b1, 1'b0, 8'h48, 4'hF, 32'h0,        32'h0000FFFF, 1'b0, 8'd9 },
        '{1'b0, 1'b1, 8'h40, 4'h2, 32'h0000AB00, 32'h0,        1'b0, 8'd9 },  // R9 upper lane only
        '{1'b0, 1'b0, 8'h40, 4'hF, 32'h0,        32'h0000AB00, 1'b0, 8'd9 },
        '{1'b1, 1'b0, 8'h88, 4'hF, 32'h0,        32'h00000000, 1'b0, 8'd10},  // R10 not yet freed
        '{1'b0, 1'b1, 8'h08, 4'h3, 32'h00000303, 32'h0,        1'b0, 8'd5 },  // R5 all-nop wide
        '{1'b0, 1'b0, 8'h08, 4'hF, 32'h0,        32'h00000000, 1'b0, 8'd5 },
        '{1'b0, 1'b1, 8'h08, 4'h1, 32'h01010101, 32'h0,        1'b0, 8'd7 },  // R7 masked lanes
        '{1'b0, 1'b0, 8'h08, 4'hF, 32'h0,        32'h00000001, 1'b0, 8'd7 }
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rid = 1'b0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [1:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] rd_s;
    logic        err_s;

    always #10 clk = ~clk;

    sema_gates u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_be   (bus_be),
        .bus_wdata(bus_wdata),
        .bus_rid  (bus_rid),
        .bus_rdata(bus_rdata),
        .bus_err  (bus_err),
        .irq      (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus access: drive at falling edge, sample mid-cycle, commit at rising edge
    task automatic acc(input logic rid, input logic we, input logic [7:0] addr,
                       input logic [3:0] be, input logic [31:0] wd);
        @(negedge clk);
        bus_sel = 1'b1; bus_rid = rid; bus_we = we;
        bus_addr = addr; bus_be = be; bus_wdata = wd;
        #2;
        rd_s = bus_rdata;
        err_s = bus_err;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic rid, input logic [7:0] addr,
                          input logic [31:0] exp);
        acc(rid, 1'b0, addr, 4'hF, 32'h0);
        chk(req, rd_s, exp);
    endtask

    task automatic irq_chk(input string req, input logic [1:0] exp);
        #5;
        chk(req, 32'(irq), 32'(exp));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        irq_chk("R1 irq after reset", 2'b00);
        rd_chk("R1 enable p0 after reset", 1'b0, 8'h40, 32'h0);
        rd_chk("R1 ntf p1 after reset", 1'b1, 8'h88, 32'h0);

        for (int i = 0; i < NV; i++) begin
            acc(VEC[i].rid, VEC[i].we, VEC[i].addr, VEC[i].be, VEC[i].wd);
            checks++;
            if (err_s !== VEC[i].err) begin
                errors++;
                $display("FAIL R%0d vec%0d err actual=%b expected=%b", VEC[i].req, i, err_s, VEC[i].err);
            end
            if (!VEC[i].we) begin
                checks++;
                if (rd_s !== VEC[i].rd) begin
                    errors++;
                    $display("FAIL R%0d vec%0d rdata actual=%h expected=%h", VEC[i].req, i, rd_s, VEC[i].rd);
                end
            end
        end

        // R11: p1 waits on gate1 but nothing freed yet
        irq_chk("R11 idle", 2'b00);
        // R10: p0 frees gate1, p1 had failed there
        acc(1'b0, 1'b1, 8'h00, 4'h2, 32'h0);
        irq_chk("R11 p1 irq on free", 2'b10);
        rd_chk("R10 ntf p1 bit1", 1'b1, 8'h88, 32'h00000002);
        rd_chk("R13 ntf p0 empty", 1'b0, 8'h80, 32'h0);
        acc(1'b1, 1'b1, 8'h88, 4'hF, 32'h0);
        rd_chk("R10 ntf read-only", 1'b1, 8'h88, 32'h00000002);
        // R12: p1 takes gate1
        acc(1'b1, 1'b1, 8'h00, 4'h2, 32'h00000200);
        irq_chk("R12 irq drops on lock", 2'b00);
        rd_chk("R12 ntf p1 cleared", 1'b1, 8'h88, 32'h0);
        rd_chk("R2 gate1 held by p1", 1'b0, 8'h00, 32'h00000200);
        // R13: p1 frees gate1, nobody waited
        acc(1'b1, 1'b1, 8'h00, 4'h2, 32'h0);
        rd_chk("R13 no ntf p0", 1'b0, 8'h80, 32'h0);
        rd_chk("R13 no ntf p1", 1'b1, 8'h88, 32'h0);
        // R11 with enable clear: p0 fails on gate6, p1 frees it
        acc(1'b0, 1'b1, 8'h04, 4'h4, 32'h00010000);
        acc(1'b1, 1'b1, 8'h04, 4'h4, 32'h0);
        rd_chk("R10 ntf p0 bit6", 1'b0, 8'h80, 32'h00000040);
        irq_chk("R11 masked", 2'b00);
        acc(1'b0, 1'b1, 8'h40, 4'h1, 32'hFFFF0040);
        rd_chk("R9 lane0 write keeps lane1", 1'b0, 8'h40, 32'h0000AB40);
        irq_chk("R11 unmasked", 2'b01);
        acc(1'b0, 1'b1, 8'h04, 4'h4, 32'h00010000);
        irq_chk("R12 p0 lock clears irq", 2'b00);
        // R5: upper bits set leaves gate alone
        acc(1'b1, 1'b1, 8'h0C, 4'h1, 32'h00000006);
        rd_chk("R5 odd byte ignored", 1'b0, 8'h0C, 32'h0);

        // R1: reset mid-run
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        irq_chk("R1 irq after re-reset", 2'b00);
        rd_chk("R1 gates 4..7 free", 1'b0, 8'h04, 32'h0);
        rd_chk("R1 gates 8..11 free", 1'b0, 8'h08, 32'h0);
        rd_chk("R1 enable p1 cleared", 1'b1, 8'h48, 32'h0);
        rd_chk("R1 enable p0 cleared", 1'b0, 8'h40, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule